// File: doc/BRIEF.md
# Parallel PROM Read Controller

This block lets a synchronous system bus read bytes from an asynchronous 2048-by-8 programmable read-only memory. A requester raises a one-cycle read strobe with an 11-bit address. The controller places the address on the memory pins and asserts the three chip selects together. It then waits a number of clock cycles that it derives at elaboration time from the memory's access timing. It captures the byte and hands it back with a single-cycle valid flag.

After each access the controller releases the selects and keeps them released long enough for the memory's outputs to float. Only then does it allow another access to begin. A strobe that arrives while an access or a recovery is running is kept in a one-entry hold slot and issued as soon as the float interval ends.

The speed grade and the clock period are parameters. All three wait counts are rounded up to whole cycles, and none of them is ever smaller than one cycle. Programming the memory is not part of this block.

Top module: `prom_rd_ctrl`

## Requirements
- R1: Out of reset, the selects are inactive (`mem_sel_low_n`=1, `mem_sel_hi_a`=0, `mem_sel_hi_b`=0), and `busy` and `rd_valid` are both 0.
- R2: The access wait W is the larger of ceil(tAA/T) and ceil(tSEL/T), where tAA is 70 ns (fast grade) or 90 ns (slow grade) and tSEL is 20 ns or 30 ns. The float wait D is ceil(tFLT/T), where tFLT is 20 ns or 30 ns. Both W and D are at least 1. With the fast grade at T=5 ns, this gives W=14 and D=4.
- R3: The memory is selected only as the pattern `mem_sel_low_n`=0, `mem_sel_hi_a`=1, `mem_sel_hi_b`=1. When deselected, all three selects go inactive together in the same cycle.
- R4: `mem_addr` is loaded in the same edge that asserts the selects. It stays unchanged for the whole access and until the next access starts.
- R5: If a strobe is accepted at clock edge E0, `rd_valid` is high for exactly one cycle, after edge E0+W. At that point `rd_data` carries the byte stored at the strobed address, and `rd_data` keeps that value afterwards.
- R6: After the selects are released, they are not asserted again for at least D cycles.
- R7: `busy` is high from the edge that accepts a strobe until recovery has ended with the hold slot empty.
- R8: A strobe taken while the hold slot is empty and an access or recovery is in progress is stored with its address. It is serviced later with that same address.
- R9: A strobe that arrives while the hold slot is full is ignored. It produces no access and no `rd_valid` pulse.
- R10: A held request, or a strobe present in the last recovery cycle, starts its access in the edge that ends recovery, with no idle cycle in between.
- R11: The captured `rd_data` never contains X or Z bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read strobe, sampled on each rising edge |
| rd_addr | input | 11 | Byte address for the strobe |
| busy | output | 1 | Access or recovery in progress, or a request held |
| rd_valid | output | 1 | One-cycle pulse, read data present |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 11 | Address pins to the memory |
| mem_sel_low_n | output | 1 | Select, active low |
| mem_sel_hi_a | output | 1 | Select, active high |
| mem_sel_hi_b | output | 1 | Select, active high |
| mem_data | input | 8 | Memory output pins, high impedance when deselected |

## Verification
The bench builds the controller with the fast grade and a 5 ns period, so W is 14 and D is 4. The memory model makes its byte valid 1 ns before the worst-case access time and drives X before that. As a result, a capture even one edge early shows up as X in `rd_data`. A second strobe is swept across every offset from the first strobe through the whole access and recovery, which reaches the hold-slot capture, the ignored third strobe and the start of an access in the same edge that ends recovery.

// File: rtl/prom_rd_pkg.sv
`timescale 1ns/1ps
// Package: timing constants and helpers shared by the PROM read controller.
// Assumes the clock period is given in whole nanoseconds.
package prom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RECOVER = 2'd2
    } rd_state_t;

    // Worst-case address-to-data time in ns for the selected grade.
    function automatic int addr_to_data_ns(input bit slow);
        return slow ? 90 : 70;
    endfunction

    // Worst-case select-to-data time in ns for the selected grade.
    function automatic int sel_to_data_ns(input bit slow);
        return slow ? 30 : 20;
    endfunction

    // Worst-case deselect-to-float time in ns for the selected grade.
    function automatic int float_ns(input bit slow);
        return slow ? 30 : 20;
    endfunction

    // Rounds n/d upwards.
    function automatic int ceil_div(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

    // Converts a time in ns to cycles, never fewer than one.
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        int c;
        c = ceil_div(t_ns, period_ns);
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prom_wait_timer.sv
`timescale 1ns/1ps
// Module: loadable down-counter that marks the end of a wait interval.
// Assumes LOAD_VAL has already been reduced by one by the caller, so that a
// load of N-1 gives N cycles until the next zero-qualified edge.
module prom_wait_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new interval or count down towards zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // The counter must rest at zero, never wrap, while nothing is loaded.
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/prom_req_slot.sv
`timescale 1ns/1ps
// Module: one-entry hold slot for strobes that arrive while the controller is
// busy. Assumes 'start' is the controller's access-start decision of this
// cycle; when the slot is full, start consumes the slot.
module prom_req_slot #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              start,
    output logic              full,
    output logic [ADDR_W-1:0] addr_q
);

    logic take;
    assign take = start && full;

    // Refill on consumption, capture a new strobe when empty, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            addr_q <= '0;
        end else if (take) begin
            full   <= req;
            addr_q <= req_addr;
        end else if (req && !full && !start) begin
            full   <= 1'b1;
            addr_q <= req_addr;
        end
    end

    // A held request keeps its address until it is issued.
    p_slot_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !start) |=> (full && $stable(addr_q)));

endmodule

// File: rtl/prom_pin_drv.sv
`timescale 1ns/1ps
// Module: registers on the memory pins: address, chip selects of mixed
// polarity, and the capture register for returned data.
// Assumes 'start' and 'capture' are never high in the same cycle.
module prom_pin_drv #(
    parameter int                ADDR_W  = 11,
    parameter int                DATA_W  = 8,
    parameter int                NUM_SEL = 3,
    parameter logic [NUM_SEL-1:0] SEL_ON = 3'b110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               capture,
    input  logic [DATA_W-1:0]  mem_data_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [NUM_SEL-1:0] sel_o,
    output logic [DATA_W-1:0]  data_o,
    output logic               en_o
);

    // Track whether the memory is currently selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= 1'b0;
        end else if (start) begin
            en_o <= 1'b1;
        end else if (capture) begin
            en_o <= 1'b0;
        end
    end

    // Load the address pins only when an access begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (start) begin
            addr_o <= addr_in;
        end
    end

    // Sample the memory bus on the final wait edge, before the address moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
        end else if (capture) begin
            data_o <= mem_data_i;
        end
    end

    // One register per select, each with its own active level.
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_o[i] <= ~SEL_ON[i];
            end else if (start) begin
                sel_o[i] <= SEL_ON[i];
            end else if (capture) begin
                sel_o[i] <= ~SEL_ON[i];
            end
        end
    end

    // All selects switch as one group: all active or all inactive.
    p_sel_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == SEL_ON) || (sel_o == ~SEL_ON));

    // The address pins are steady for as long as the memory is selected.
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && $past(en_o)) |-> $stable(addr_o));

endmodule

// File: rtl/prom_rd_ctrl.sv
`timescale 1ns/1ps
// Module: top of the PROM read controller. Sequences idle, access and
// float-recovery phases, with wait counts derived from the speed grade and
// the clock period. Assumes the memory is asynchronous and selected only
// when the low-active select is 0 and both high-active selects are 1.
module prom_rd_ctrl
    import prom_rd_pkg::*;
#(
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 5,
    parameter bit SLOW_GRADE    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_low_n,
    output logic              mem_sel_hi_a,
    output logic              mem_sel_hi_b,
    input  logic [DATA_W-1:0] mem_data
);

    localparam int ADDR_CYC = ns_to_cycles(addr_to_data_ns(SLOW_GRADE), CLK_PERIOD_NS);
    localparam int SEL_CYC  = ns_to_cycles(sel_to_data_ns(SLOW_GRADE), CLK_PERIOD_NS);
    localparam int WAIT_ACC = imax(ADDR_CYC, SEL_CYC);
    localparam int WAIT_FLT = ns_to_cycles(float_ns(SLOW_GRADE), CLK_PERIOD_NS);
    localparam int CNT_W    = $clog2(imax(WAIT_ACC, WAIT_FLT) + 1);
    localparam int NUM_SEL  = 3;

    rd_state_t         state_q;
    logic              tmr_zero;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              slot_full;
    logic [ADDR_W-1:0] slot_addr;
    logic              start_ok;
    logic              go;
    logic              capture;
    logic [ADDR_W-1:0] start_addr;
    logic [NUM_SEL-1:0] sel_pins;
    logic              sel_en;

    // Decide whether an access starts or ends in this cycle.
    always_comb begin
        start_ok   = (state_q == ST_IDLE) || ((state_q == ST_RECOVER) && tmr_zero);
        go         = start_ok && (slot_full || rd_req);
        capture    = (state_q == ST_ACCESS) && tmr_zero;
        start_addr = slot_full ? slot_addr : rd_addr;
        tmr_load   = go || capture;
        tmr_val    = go ? CNT_W'(WAIT_ACC - 1) : CNT_W'(WAIT_FLT - 1);
    end

    // Phase sequencing: idle, access, recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (go) begin
            state_q <= ST_ACCESS;
        end else if (capture) begin
            state_q <= ST_RECOVER;
        end else if ((state_q == ST_RECOVER) && tmr_zero) begin
            state_q <= ST_IDLE;
        end
    end

    // Single-cycle completion flag, raised in the capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
        end
    end

    assign busy = (state_q != ST_IDLE) || slot_full;

    prom_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    prom_req_slot #(
        .ADDR_W (ADDR_W)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rd_req),
        .req_addr (rd_addr),
        .start    (go),
        .full     (slot_full),
        .addr_q   (slot_addr)
    );

    prom_pin_drv #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_SEL (NUM_SEL),
        .SEL_ON  (3'b110)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (go),
        .addr_in    (start_addr),
        .capture    (capture),
        .mem_data_i (mem_data),
        .addr_o     (mem_addr),
        .sel_o      (sel_pins),
        .data_o     (rd_data),
        .en_o       (sel_en)
    );

    assign mem_sel_low_n = sel_pins[0];
    assign mem_sel_hi_a  = sel_pins[1];
    assign mem_sel_hi_b  = sel_pins[2];

    // Assertion support: cycles the selects have been active, and cycles
    // they have been released (saturating, preset so reset counts as floated).
    logic [CNT_W:0]   acc_len_q;
    logic [CNT_W-1:0] gap_q;

    // Count cycles with the memory selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_len_q <= '0;
        end else if (sel_en) begin
            acc_len_q <= acc_len_q + 1'b1;
        end else begin
            acc_len_q <= '0;
        end
    end

    // Count cycles with the memory deselected, saturating at the float wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= CNT_W'(WAIT_FLT);
        end else if (sel_en) begin
            gap_q <= '0;
        end else if (gap_q < CNT_W'(WAIT_FLT)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_access_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (acc_len_q == (CNT_W+1)'(WAIT_ACC)));

    p_float_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_en) |-> (gap_q >= CNT_W'(WAIT_FLT)));

    p_busy_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

endmodule

// File: tb/sim_prom_rd_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural memory model plus a cycle-level reference model of the
// controller's visible behaviour, compared on every falling edge.
module sim_prom_rd_ctrl;

    localparam int EXP_W = 14;   // R2: ceil(70/5)
    localparam int EXP_D = 4;    // R2: ceil(20/5)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [10:0] rd_addr = '0;
    logic        busy, rd_valid;
    logic [7:0]  rd_data;
    logic [10:0] mem_addr;
    logic        mem_sel_low_n, mem_sel_hi_a, mem_sel_hi_b;
    logic [7:0]  mem_bus;

    int n_chk = 0;
    int n_bad = 0;
    int n_valid = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    prom_rd_ctrl #(
        .CLK_PERIOD_NS (5),
        .SLOW_GRADE    (1'b0)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_req        (rd_req),
        .rd_addr       (rd_addr),
        .busy          (busy),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .mem_addr      (mem_addr),
        .mem_sel_low_n (mem_sel_low_n),
        .mem_sel_hi_a  (mem_sel_hi_a),
        .mem_sel_hi_b  (mem_sel_hi_b),
        .mem_data      (mem_bus)
    );

    // Stored byte for every address, computed rather than listed.
    function automatic logic [7:0] rom_byte(input logic [10:0] a);
        logic [15:0] t;
        t = 16'(a) * 16'd29 + 16'(a >> 4);
        return t[7:0] ^ 8'h5a;
    endfunction

    // Memory model: X until access time has run out, Z when deselected.
    logic    chip_en;
    realtime t_addr = 0.0;
    realtime t_sel  = 0.0;
    assign chip_en = !mem_sel_low_n && mem_sel_hi_a && mem_sel_hi_b;

    always @(mem_addr) t_addr = $realtime;
    always @(posedge chip_en) t_sel = $realtime;

    always begin
        #0.5;
        if (chip_en !== 1'b1)
            mem_bus = 'z;
        else if (($realtime - t_addr >= 69.0) && ($realtime - t_sel >= 19.0))
            mem_bus = rom_byte(mem_addr);
        else
            mem_bus = 'x;
    end

    // Reference model state.
    int          m_ph = 0;  // 0 idle, 1 access, 2 recovery
    int          m_cnt = 0;
    bit          m_pend = 1'b0;
    logic [10:0] m_paddr = '0;
    logic [10:0] m_addr = '0;
    bit          m_sel = 1'b0;
    bit          m_valid = 1'b0;
    logic [7:0]  m_data = '0;

    // Advance the reference model on each rising edge.
    always @(posedge clk) begin
        bit ok_start, go;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_pend = 0; m_paddr = '0; m_addr = '0;
            m_sel = 0; m_valid = 0; m_data = '0;
        end else begin
            ok_start = (m_ph == 0) || (m_ph == 2 && m_cnt == 0);
            go = ok_start && (m_pend || rd_req);
            m_valid = 1'b0;
            if (m_ph == 1) begin
                if (m_cnt == 0) begin
                    m_valid = 1'b1;
                    m_data = rom_byte(m_addr);
                    m_ph = 2; m_cnt = EXP_D - 1; m_sel = 1'b0;
                end else m_cnt--;
            end else if (m_ph == 2) begin
                if (m_cnt != 0) m_cnt--;
                else if (!go) m_ph = 0;
            end
            if (go) begin
                m_addr = m_pend ? m_paddr : rd_addr;
                m_ph = 1; m_cnt = EXP_W - 1; m_sel = 1'b1;
                if (m_pend) begin
                    m_pend = rd_req;
                    m_paddr = rd_addr;
                end
            end else if (rd_req && !m_pend) begin
                m_pend = 1'b1;
                m_paddr = rd_addr;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every visible output against the reference model.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(busy === (m_ph != 0 || m_pend), "R7 busy", 32'(busy), 32'(m_ph != 0 || m_pend));
            chk(rd_valid === m_valid, "R5 valid", 32'(rd_valid), 32'(m_valid));
            chk({mem_sel_low_n, mem_sel_hi_a, mem_sel_hi_b} === (m_sel ? 3'b011 : 3'b100),
                "R3 selects", 32'({mem_sel_low_n, mem_sel_hi_a, mem_sel_hi_b}),
                32'(m_sel ? 3'b011 : 3'b100));
            chk(mem_addr === m_addr, "R4 addr", 32'(mem_addr), 32'(m_addr));
            chk(rd_data === m_data, "R5 data", 32'(rd_data), 32'(m_data));
            if (rd_valid === 1'b1) begin
                n_valid++;
                chk(!$isunknown(rd_data), "R11 no X/Z", 32'(rd_data), 32'(m_data));
            end
        end
    end

    task automatic strobe(input logic [10:0] a);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy === 1'b1);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        int v0;
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        // R1: reset state
        chk({mem_sel_low_n, mem_sel_hi_a, mem_sel_hi_b} === 3'b100, "R1 selects",
            32'({mem_sel_low_n, mem_sel_hi_a, mem_sel_hi_b}), 32'h4);
        chk(busy === 1'b0 && rd_valid === 1'b0, "R1 busy/valid", 32'({busy, rd_valid}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: latency to valid is W+1 falling edges, recovery D more.
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 11'h123;
        cyc = 0;
        @(negedge clk);
        rd_req = 1'b0; cyc = 1;
        while (rd_valid !== 1'b1 && cyc < 100) begin @(negedge clk); cyc++; end
        chk(cyc == EXP_W + 1, "R2 access wait", 32'(cyc), 32'(EXP_W + 1));
        cyc = 0;
        while (busy === 1'b1 && cyc < 100) begin @(negedge clk); cyc++; end
        chk(cyc == EXP_D, "R2 float wait", 32'(cyc), 32'(EXP_D));
        wait_idle();

        // R5: corner and pattern addresses
        strobe(11'h000); wait_idle();
        strobe(11'h7ff); wait_idle();
        strobe(11'h555); wait_idle();
        strobe(11'h2aa); wait_idle();

        // R8, R10, R6: second strobe swept over the whole access and recovery
        for (int off = 0; off < EXP_W + EXP_D + 3; off++) begin
            strobe(11'(off * 37 + 5));
            repeat (off) @(negedge clk);
            strobe(11'(off * 91 + 3));
            wait_idle();
        end

        // R9: third strobe while the slot is full is ignored
        v0 = n_valid;
        strobe(11'h0f0);
        strobe(11'h10f);
        strobe(11'h3c3);
        wait_idle();
        chk(n_valid - v0 == 2, "R9 ignored strobe", 32'(n_valid - v0), 32'd2);

        // R10: strobe held high keeps accesses back to back
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 11'h6a6;
        repeat (60) @(negedge clk);
        rd_req = 1'b0;
        wait_idle();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule